// File: doc/BRIEF.md
# UART Length-Prefixed Program Loader

This block takes a program image delivered one byte at a time by a serial receiver and stores it into two word-wide memories. The stream opens with a four-byte count giving how many payload bytes follow. The loader then packs the payload into 32-bit words, least significant byte first. Each finished word is written to a data memory at consecutive word addresses. The same word also goes to an instruction memory built as two interleaved banks, so that fetch can later read one aligned 64-bit pair of instructions per cycle.

The byte interface is a level strobe `rx_done` with `rx_byte`. A byte is taken on the first cycle the strobe is seen high, and the next byte is accepted only after the strobe has dropped. Control is a three-state machine. `LD_HEADER` collects the count. From there the transition *header-nonzero* leads to `LD_PAYLOAD`, and the transition *header-zero* leads directly to `LD_FINISHED`. In `LD_PAYLOAD`, the transition *last-byte* (the remaining count reaches zero) leads to `LD_FINISHED`. `LD_FINISHED` is left only by reset. A payload that is not a multiple of four ends with a short word, which is flushed at once with its unused upper bytes set to zero.

Top module: `prog_loader`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `dmem_we`, `imem_we0`, `imem_we1` and `load_done` are 0 and `dmem_addr` is 0.
- R2: The first four accepted bytes form the payload byte count N, little-endian: the first byte is bits [7:0] and the fourth byte is bits [31:24].
- R3: Each byte is accepted exactly once. While `rx_done` stays high, no further byte is taken; a new byte is taken only after `rx_done` has been low for at least one cycle.
- R4: Payload bytes are packed little-endian, with the first byte of each group in bits [7:0]. Accepting the fourth byte of a group raises `dmem_we` with that word in the cycle after the accepting clock edge.
- R5: When the remaining count reaches zero partway through a group, the partial word is written at once, with its unfilled bytes equal to zero.
- R6: Data-memory words are written at `dmem_addr` 0, 1, 2, … in order. Every write uses `dmem_mask` = 4'b1111, and N bytes give exactly ceil(N/4) writes.
- R7: `load_done` rises in the same cycle as the write of the last word, stays high until reset, and bytes received after that cause no memory write.
- R8: A count of zero raises `load_done` in the cycle after the fourth header byte is accepted, and no memory write follows.
- R9: Word k is written to instruction bank k[0] (`imem_we0` for even k, `imem_we1` for odd k) at `imem_addr` = k>>1. The data is the same word, and the write happens one cycle after its data-memory write. The two bank enables are never high together.
- R10: Words with index k ≥ IMEM_WORDS (default 4096) produce no instruction-memory write, but data-memory writes continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Byte-available level strobe from the receiver |
| rx_byte | input | 8 | Received byte, valid while `rx_done` is high |
| dmem_we | output | 1 | Data-memory write enable |
| dmem_addr | output | DADDR_W (16) | Data-memory word address |
| dmem_wdata | output | 32 | Data-memory write word |
| dmem_mask | output | 4 | Data-memory byte mask |
| imem_we0 | output | 1 | Instruction bank 0 (even words) write enable |
| imem_we1 | output | 1 | Instruction bank 1 (odd words) write enable |
| imem_addr | output | $clog2(IMEM_WORDS)-1 (11) | Bank word address |
| imem_wdata | output | 32 | Instruction-memory write word |
| load_done | output | 1 | Image fully received |

## Verification
Two functions can complete on the same byte: word-full (the fourth byte of a group) and count-exhausted (the last payload byte). When this happens, one flush must serve both, with no extra write and with `load_done` rising together with that write. The bench provokes the coincidence with counts that are multiples of four, and it provokes the non-coincident case with counts of 1, 7 and random values. Each write is judged against words computed from the sent bytes, together with the final write counts and the `load_done` timing.

// File: rtl/loader_pkg.sv
package loader_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        LD_HEADER   = 2'd0,
        LD_PAYLOAD  = 2'd1,
        LD_FINISHED = 2'd2
    } ld_state_e;
endpackage

// File: rtl/ldr_rx_gate.sv
// Turns the receiver's level strobe into a one-cycle take pulse per byte.
module ldr_rx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_done,
    output logic take
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (!rx_done) seen_q <= 1'b0;
        else              seen_q <= 1'b1;
    end

    assign take = rx_done & ~seen_q;
endmodule

// File: rtl/ldr_ctrl.sv
// Header collection, payload packing and the load state machine.
module ldr_ctrl
    import loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [7:0]        rx_byte,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_dat,
    output logic              done
);
    ld_state_e         state_q, state_d;
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] hdr_q, remain_q, pack_q;
    logic [WORD_W-1:0] hdr_full, pack_next, byte_shift;
    logic              group_end;

    always_comb begin
        byte_shift = {{(WORD_W-8){1'b0}}, rx_byte} << {lane_q, 3'b000};
        hdr_full   = hdr_q  | byte_shift;
        pack_next  = pack_q | byte_shift;
        group_end  = (lane_q == LANE_W'(LANES-1)) || (remain_q == WORD_W'(1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_HEADER: begin
                if (take && lane_q == LANE_W'(LANES-1))
                    state_d = (hdr_full == '0) ? LD_FINISHED : LD_PAYLOAD;
            end
            LD_PAYLOAD: begin
                if (take && remain_q == WORD_W'(1))
                    state_d = LD_FINISHED;
            end
            LD_FINISHED: state_d = LD_FINISHED;
            default:     state_d = LD_HEADER;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_HEADER;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q   <= '0;
            hdr_q    <= '0;
            remain_q <= '0;
            pack_q   <= '0;
            word_vld <= 1'b0;
            word_dat <= '0;
            done     <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            done     <= (state_d == LD_FINISHED);
            unique case (state_q)
                LD_HEADER: begin
                    if (take) begin
                        hdr_q  <= hdr_full;
                        lane_q <= lane_q + 1'b1;
                        if (lane_q == LANE_W'(LANES-1))
                            remain_q <= hdr_full;
                    end
                end
                LD_PAYLOAD: begin
                    if (take) begin
                        remain_q <= remain_q - 1'b1;
                        if (group_end) begin
                            word_vld <= 1'b1;
                            word_dat <= pack_next;
                            pack_q   <= '0;
                            lane_q   <= '0;
                        end else begin
                            pack_q   <= pack_next;
                            lane_q   <= lane_q + 1'b1;
                        end
                    end
                end
                LD_FINISHED: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ldr_bank_split.sv
// Routes each word to the even or odd instruction bank, bounded by IMEM_WORDS.
module ldr_bank_split
    import loader_pkg::*;
#(
    parameter int IMEM_WORDS = 4096,
    localparam int IDX_W     = $clog2(IMEM_WORDS) + 1,
    localparam int IBANK_AW  = $clog2(IMEM_WORDS) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_vld,
    input  logic [WORD_W-1:0]   word_dat,
    output logic                we_even,
    output logic                we_odd,
    output logic [IBANK_AW-1:0] bank_addr,
    output logic [WORD_W-1:0]   bank_data
);
    logic [IDX_W-1:0] idx_q;
    logic             in_range;

    assign in_range = (idx_q < IDX_W'(IMEM_WORDS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            we_even   <= 1'b0;
            we_odd    <= 1'b0;
            bank_addr <= '0;
            bank_data <= '0;
        end else begin
            we_even <= 1'b0;
            we_odd  <= 1'b0;
            if (word_vld && in_range) begin
                we_even   <= ~idx_q[0];
                we_odd    <=  idx_q[0];
                bank_addr <= idx_q[IBANK_AW:1];
                bank_data <= word_dat;
                idx_q     <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/prog_loader.sv
module prog_loader
    import loader_pkg::*;
#(
    parameter int DADDR_W    = 16,
    parameter int IMEM_WORDS = 4096,
    localparam int IBANK_AW  = $clog2(IMEM_WORDS) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_done,
    input  logic [7:0]          rx_byte,
    output logic                dmem_we,
    output logic [DADDR_W-1:0]  dmem_addr,
    output logic [31:0]         dmem_wdata,
    output logic [3:0]          dmem_mask,
    output logic                imem_we0,
    output logic                imem_we1,
    output logic [IBANK_AW-1:0] imem_addr,
    output logic [31:0]         imem_wdata,
    output logic                load_done
);
    logic              take;
    logic              word_vld;
    logic [WORD_W-1:0] word_dat;
    logic [DADDR_W-1:0] dptr_q;

    ldr_rx_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_done (rx_done),
        .take    (take)
    );

    ldr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .rx_byte  (rx_byte),
        .word_vld (word_vld),
        .word_dat (word_dat),
        .done     (load_done)
    );

    ldr_bank_split #(.IMEM_WORDS(IMEM_WORDS)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .word_dat  (word_dat),
        .we_even   (imem_we0),
        .we_odd    (imem_we1),
        .bank_addr (imem_addr),
        .bank_data (imem_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        dptr_q <= '0;
        else if (word_vld) dptr_q <= dptr_q + 1'b1;
    end

    assign dmem_we    = word_vld;
    assign dmem_addr  = dptr_q;
    assign dmem_wdata = word_dat;
    assign dmem_mask  = {LANES{1'b1}};
endmodule

// File: rtl/loader_chk.sv
module loader_chk #(
    parameter int DADDR_W  = 16,
    parameter int IBANK_AW = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_done,
    input logic                dmem_we,
    input logic [DADDR_W-1:0]  dmem_addr,
    input logic [31:0]         dmem_wdata,
    input logic                imem_we0,
    input logic                imem_we1,
    input logic [31:0]         imem_wdata,
    input logic                load_done
);
    AST_BANK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({imem_we0, imem_we1}) <= 1); // R9

    AST_IMEM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we0 || imem_we1) |-> ($past(dmem_we) && imem_wdata == $past(dmem_wdata))); // R9

    AST_DADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dmem_we) |-> dmem_addr == $past(dmem_addr) + 1'b1); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done); // R7

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_done) |-> !dmem_we); // R7

    AST_WORD_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> $past(rx_done)); // R3
endmodule

bind prog_loader loader_chk #(.DADDR_W(DADDR_W), .IBANK_AW(IBANK_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_done    (rx_done),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .imem_we0   (imem_we0),
    .imem_we1   (imem_we1),
    .imem_wdata (imem_wdata),
    .load_done  (load_done)
);

// File: tb/prog_loader_tb.sv
module prog_loader_tb;
    localparam int DADDR_W  = 16;
    localparam int IMEM_W   = 4096;
    localparam int IBANK_AW = $clog2(IMEM_W) - 1;
    localparam int MAXB     = 16420;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic dmem_we, imem_we0, imem_we1, load_done;
    logic [DADDR_W-1:0] dmem_addr;
    logic [31:0] dmem_wdata, imem_wdata;
    logic [3:0] dmem_mask;
    logic [IBANK_AW-1:0] imem_addr;

    always #4 clk = ~clk;

    prog_loader #(.DADDR_W(DADDR_W), .IMEM_WORDS(IMEM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_mask(dmem_mask), .imem_we0(imem_we0), .imem_we1(imem_we1),
        .imem_addr(imem_addr), .imem_wdata(imem_wdata), .load_done(load_done)
    );

    int checks = 0;
    int failures = 0;
    logic [7:0] pay [0:MAXB-1];
    int n_bytes = 0;
    int dm_cnt = 0;
    int im_cnt = 0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k);
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++)
            if (4*k + b < n_bytes) w[8*b +: 8] = pay[4*k + b];
        return w;
    endfunction

    // write monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (dmem_we) begin
                chk(dmem_addr == DADDR_W'(dm_cnt), "R6 dmem_addr", 32'(dmem_addr), dm_cnt);
                chk(dmem_mask == 4'hF, "R6 mask", 32'(dmem_mask), 32'hF);
                chk(dmem_wdata == exp_word(dm_cnt), "R4/R5 dmem word", dmem_wdata, exp_word(dm_cnt));
                dm_cnt++;
            end
            if (imem_we0 || imem_we1) begin
                chk(im_cnt < IMEM_W, "R10 imem in bounds", im_cnt, IMEM_W - 1);
                chk(imem_we1 == im_cnt[0] && imem_we0 == !im_cnt[0], "R9 bank select",
                    {imem_we1, imem_we0}, im_cnt[0] ? 2 : 1);
                chk(imem_addr == IBANK_AW'(im_cnt >> 1), "R9 bank addr", 32'(imem_addr), im_cnt >> 1);
                chk(imem_wdata == exp_word(im_cnt), "R9 imem word", imem_wdata, exp_word(im_cnt));
                im_cnt++;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int hold, input int gap);
        @(negedge clk);
        rx_done = 1'b1;
        rx_byte = b;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk);
        rx_done = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        rx_done = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dmem_we && !imem_we0 && !imem_we1 && !load_done && dmem_addr == 0,
            "R1 in reset", {dmem_we, imem_we0, imem_we1, load_done}, 0);
        dm_cnt = 0;
        im_cnt = 0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(!dmem_we && !load_done && dmem_addr == 0, "R1 after release",
            {dmem_we, load_done}, 0);
    endtask

    // Loads n random payload bytes; rnd selects random strobe hold/gap.
    task automatic run_load(input int n, input bit rnd);
        int hold, gap, words, im_exp;
        do_reset();
        n_bytes = n;
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
        for (int i = 0; i < 4; i++) begin
            hold = rnd ? 1 + int'($urandom % 5) : 1;
            gap  = rnd ? 1 + int'($urandom % 3) : 1;
            send_byte(8'(n >> (8*i)), hold, gap);
        end
        @(negedge clk);
        if (n == 0)
            chk(load_done == 1'b1, "R8 zero header done", 32'(load_done), 1);
        else
            chk(load_done == 1'b0, "R2 count read, not done", 32'(load_done), 0);
        for (int i = 0; i < n; i++) begin
            hold = rnd ? 1 + int'($urandom % 5) : 1;
            gap  = rnd ? 1 + int'($urandom % 3) : 1;
            if (i == n - 1)
                chk(load_done == 1'b0, "R7 not done before last byte", 32'(load_done), 0);
            send_byte(pay[i], hold, gap);
        end
        repeat (4) @(negedge clk);
        words  = (n + 3) / 4;
        im_exp = (words < IMEM_W) ? words : IMEM_W;
        chk(load_done == 1'b1, "R7 done after load", 32'(load_done), 1);
        chk(dm_cnt == words, "R3/R6 dmem write count", dm_cnt, words);
        chk(im_cnt == im_exp, "R10 imem write count", im_cnt, im_exp);
        send_byte(8'hA5, 2, 1);
        send_byte(8'h5A, 1, 1);
        repeat (3) @(negedge clk);
        chk(dm_cnt == words && im_cnt == im_exp, "R7 bytes ignored after done", dm_cnt, words);
        chk(load_done == 1'b1, "R7 done sticky", 32'(load_done), 1);
    endtask

    // Directed timing: word write appears one cycle after the accepting edge.
    task automatic timing_test();
        do_reset();
        n_bytes = 4;
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
        for (int i = 0; i < 4; i++) send_byte(8'(i == 0 ? 4 : 0), 1, 1);
        for (int i = 0; i < 3; i++) send_byte(pay[i], 1, 1);
        @(negedge clk);
        rx_done = 1'b1;
        rx_byte = pay[3];
        @(posedge clk);
        #2;
        chk(dmem_we == 1'b1, "R4 write after accepting edge", 32'(dmem_we), 1);
        chk(dmem_wdata == 32'h44332211, "R4 little-endian word", dmem_wdata, 32'h44332211);
        chk(load_done == 1'b1, "R7 done with last write", 32'(load_done), 1);
        chk(!imem_we0, "R9 imem not yet", 32'(imem_we0), 0);
        @(posedge clk);
        #2;
        chk(imem_we0 == 1'b1 && dmem_we == 1'b0, "R9 imem one cycle later", 32'(imem_we0), 1);
        chk(dm_cnt == 1, "R3 held strobe taken once", dm_cnt, 1);
        @(negedge clk);
        rx_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(dm_cnt == 1, "R3 held strobe taken once", dm_cnt, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        timing_test();
        run_load(0, 1'b0);     // R8
        run_load(1, 1'b0);     // R5 one-byte short word
        run_load(4, 1'b1);     // word-full and count-end coincide
        run_load(7, 1'b1);     // R5 partial final word
        run_load(8, 1'b1);
        run_load(256, 1'b0);   // R2 count needs second header byte
        for (int t = 0; t < 6; t++)
            run_load(1 + int'($urandom % 60), 1'b1);
        run_load(4 * (IMEM_W + 3) + 2, 1'b0); // R10 beyond bank capacity
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule